// File: doc/BRIEF.md
# Flag-Delimited Serial Frame Transmitter with CRC-16 Trailer

This block turns a stream of bytes into a continuous one-bit-per-clock line signal carrying bit-oriented frames. While no frame is waiting, the line carries flag octets back to back. When a byte is offered, the flag that is then on the line becomes the opening flag. The bytes follow most significant bit first. The first two bytes of a frame are the header and the rest is the body; the block passes all of them through unchanged. After the final byte, a 16-bit check field goes out, and then a closing flag.

Between the flags, the block inserts a zero after every run of five ones, so the flag pattern can never appear inside a frame. The flags themselves are never altered. The byte side uses a valid/ready handshake with a last marker. Ready is a registered state decode: it is high only during the one line bit after which the block needs its next byte. A source that has no byte at that moment closes the frame early.

Top module: `sync_bit_framer`

## Requirements
- R1: With no byte offered, the line repeats the flag 0,1,1,1,1,1,1,0 (first bit sent at left), and in_ready is high only during the final bit of each flag.
- R2: A frame consists of an opening flag (the flag during whose last bit the first byte is taken), then every byte most significant bit first, then the 16-bit check field most significant bit first, then a closing flag.
- R3: Inside a frame, after five consecutive 1s from byte or check bits, a single 0 is inserted; the line never carries more than six consecutive 1s.
- R4: Flag bits are never followed by an inserted 0, and the run of ones is cleared at every flag, so ones sent just before a flag do not count toward a run inside the frame.
- R5: The check field is the remainder of the unstuffed byte bits, shifted left by 16, divided by x^16 + x^12 + x^5 + 1, starting from an all-zero register, so the byte bits followed by the check field divide evenly.
- R6: in_ready is low during every inserted zero.
- R7: A byte is taken on a rising edge where in_valid and in_ready are both high. Inside a frame, in_ready is high only during the last data bit of a byte that was not marked last.
- R8: A byte taken with in_last high is the final byte of its frame, and in_ready stays low during its last bit.
- R9: If in_valid is low while in_ready is high during a frame, the frame ends as if the previous byte had been marked last.
- R10: A byte offered during the closing flag is taken at that flag's last bit, so one flag both ends one frame and opens the next.
- R11: When the check field ends with the fifth consecutive 1, an inserted 0 is sent before the closing flag.
- R12: During reset, tx_bit and in_ready are low. After reset is released, the line starts at the first bit of a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is offered on in_data |
| in_ready | output | 1 | The block takes the offered byte at the next rising edge |
| in_data | input | 8 | Byte to send, most significant bit first |
| in_last | input | 1 | The offered byte ends its frame |
| tx_bit | output | 1 | Serial line bit for the current clock |

## Verification
The bench builds the block with its default values: generator 0x1021, zero initial remainder and a run limit of five ones. With these values, a byte of all ones, flag-valued bytes, runs that cross byte boundaries and a check field that ends on a fifth one are all reachable with frames of one to four bytes. The bench searches two-byte frames until it finds one whose check field forces a trailing inserted zero, then sends that frame. For every frame, both the line bits and the ready pattern are compared against a stream that the bench builds itself, using long division for the check field and its own zero insertion.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int BYTE_W = 8;
  localparam int FLAG_W = 8;
  localparam logic [FLAG_W-1:0] FLAG_PATTERN = 8'b0111_1110;
  localparam int CRC_W = 16;
  localparam int IDX_W = $clog2(BYTE_W);
  localparam int CIDX_W = $clog2(CRC_W) + 1;

  typedef enum logic [1:0] {
    PH_FLAG = 2'd0,
    PH_DATA = 2'd1,
    PH_CRC  = 2'd2
  } phase_e;

  // One step of the serial remainder register, message bit d entering.
  function automatic logic [CRC_W-1:0] crc_advance(input logic [CRC_W-1:0] cur,
                                                   input logic d,
                                                   input logic [CRC_W-1:0] poly);
    logic fb;
    fb = cur[CRC_W-1] ^ d;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

  // Flag bit at position idx, position 0 sent first.
  function automatic logic flag_bit(input logic [IDX_W-1:0] idx);
    return FLAG_PATTERN[(FLAG_W-1) - int'(idx)];
  endfunction
endpackage

// File: rtl/sbf_crc_acc.sv
module sbf_crc_acc
  import sbf_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT = 16'h0000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic calc_en,
  input  logic shift_en,
  input  logic din,
  output logic msb
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        crc_q <= INIT;
    else if (clr)      crc_q <= INIT;
    else if (calc_en)  crc_q <= crc_advance(crc_q, din, POLY);
    else if (shift_en) crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end

  assign msb = crc_q[CRC_W-1];

  // R5: the register either accumulates or drains, never both in one cycle
  p_single_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(calc_en && shift_en));
endmodule

// File: rtl/sbf_run_guard.sv
module sbf_run_guard #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_phase,
  input  logic cand_bit,
  output logic stuff_now,
  output logic hit_next
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] ones_q;

  assign stuff_now = !flag_phase && (ones_q == CW'(LIMIT));
  assign hit_next  = !flag_phase && !stuff_now && cand_bit && (ones_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                      ones_q <= '0;
    else if (flag_phase || stuff_now) ones_q <= '0;
    else if (cand_bit)               ones_q <= ones_q + 1'b1;
    else                             ones_q <= '0;
  end

  // R3: the run counter never passes the insertion limit
  p_count_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= CW'(LIMIT));
endmodule

// File: rtl/sbf_frame_seq.sv
module sbf_frame_seq
  import sbf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              stuff_now,
  input  logic              hit_next,
  input  logic              crc_msb,
  output logic              in_ready,
  output logic              cand_bit,
  output logic              tx_bit,
  output logic              flag_phase,
  output logic              crc_clr,
  output logic              crc_calc,
  output logic              crc_shift
);
  phase_e             phase_q;
  logic [IDX_W-1:0]   bit_idx;
  logic [CIDX_W-1:0]  crc_idx;
  logic [BYTE_W-1:0]  byte_q;
  logic               last_q;
  logic               byte_end;
  logic               take;

  assign flag_phase = (phase_q == PH_FLAG);
  assign byte_end   = (bit_idx == IDX_W'(BYTE_W - 1));

  always_comb begin
    unique case (phase_q)
      PH_DATA: cand_bit = byte_q[BYTE_W-1];
      PH_CRC:  cand_bit = crc_msb;
      default: cand_bit = flag_bit(bit_idx);
    endcase
  end

  assign tx_bit   = stuff_now ? 1'b0 : cand_bit;
  assign in_ready = (flag_phase && byte_end) ||
                    ((phase_q == PH_DATA) && byte_end && !stuff_now && !last_q);
  assign take     = in_valid && in_ready;

  assign crc_clr   = flag_phase && take;
  assign crc_calc  = (phase_q == PH_DATA) && !stuff_now;
  assign crc_shift = (phase_q == PH_CRC) && !stuff_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_FLAG;
      bit_idx <= '0;
      crc_idx <= '0;
      byte_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_FLAG: begin
          bit_idx <= bit_idx + 1'b1;
          if (take) begin
            phase_q <= PH_DATA;
            byte_q  <= in_data;
            last_q  <= in_last;
          end
        end
        PH_DATA: begin
          if (!stuff_now) begin
            bit_idx <= bit_idx + 1'b1;
            byte_q  <= {byte_q[BYTE_W-2:0], 1'b0};
            if (byte_end) begin
              if (take) begin
                byte_q <= in_data;
                last_q <= in_last;
              end else begin
                phase_q <= PH_CRC;
                crc_idx <= '0;
              end
            end
          end
        end
        PH_CRC: begin
          if (stuff_now) begin
            if (crc_idx == CIDX_W'(CRC_W)) begin
              phase_q <= PH_FLAG;
              bit_idx <= '0;
            end
          end else begin
            crc_idx <= crc_idx + 1'b1;
            if ((crc_idx == CIDX_W'(CRC_W - 1)) && !hit_next) begin
              phase_q <= PH_FLAG;
              bit_idx <= '0;
            end
          end
        end
        default: phase_q <= PH_FLAG;
      endcase
    end
  end

  // R7: a handshake always leaves the sequencer sending byte bits
  p_take_starts_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (phase_q == PH_DATA));
endmodule

// File: rtl/sync_bit_framer.sv
module sync_bit_framer
  import sbf_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY      = 16'h1021,
  parameter logic [CRC_W-1:0] INIT      = 16'h0000,
  parameter int               RUN_LIMIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              tx_bit
);
  logic stuff_now;
  logic hit_next;
  logic cand_bit;
  logic flag_phase;
  logic crc_msb;
  logic crc_clr;
  logic crc_calc;
  logic crc_shift;

  sbf_frame_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_last    (in_last),
    .stuff_now  (stuff_now),
    .hit_next   (hit_next),
    .crc_msb    (crc_msb),
    .in_ready   (in_ready),
    .cand_bit   (cand_bit),
    .tx_bit     (tx_bit),
    .flag_phase (flag_phase),
    .crc_clr    (crc_clr),
    .crc_calc   (crc_calc),
    .crc_shift  (crc_shift)
  );

  sbf_run_guard #(.LIMIT(RUN_LIMIT)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_phase (flag_phase),
    .cand_bit   (cand_bit),
    .stuff_now  (stuff_now),
    .hit_next   (hit_next)
  );

  sbf_crc_acc #(.POLY(POLY), .INIT(INIT)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (crc_clr),
    .calc_en  (crc_calc),
    .shift_en (crc_shift),
    .din      (cand_bit),
    .msb      (crc_msb)
  );

  // Line-level run counter, observed only by the assertions below.
  logic [2:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (tx_bit) run_q <= (run_q == 3'd7) ? run_q : run_q + 1'b1;
    else             run_q <= '0;
  end

  // R3: only a flag may show six ones in a row, nothing shows seven
  p_line_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 3'd6);

  // R6: an inserted zero is a zero on the line and never offers ready
  p_stuff_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_now |-> (!tx_bit && !in_ready));

  // R11: a closing flag never starts while an insertion is still owed
  p_no_pending_stuff_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_phase && !$past(flag_phase)) |-> !$past(hit_next));
endmodule

// File: tb/test_sync_bit_framer.sv
`timescale 1ns/1ps
module test_sync_bit_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       tx_bit;

  always #2.5 clk = ~clk;

  sync_bit_framer i_sync_bit_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_last  (in_last),
    .tx_bit   (tx_bit)
  );

  localparam int MAXC = 16384;
  localparam logic [16:0] GEN = 17'h11021;
  // {length, byte0, byte1, byte2, byte3}
  localparam logic [39:0] VEC [6] = '{
    {8'd2, 8'h12, 8'h34, 8'h00, 8'h00},
    {8'd3, 8'hFF, 8'hFF, 8'hFF, 8'h00},
    {8'd4, 8'h7E, 8'h7E, 8'h00, 8'h01},
    {8'd1, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'd4, 8'hA5, 8'h5A, 8'hF0, 8'h0F},
    {8'd3, 8'h3F, 8'h1F, 8'h80, 8'h00}
  };

  bit   line_bit [MAXC];
  bit   line_rdy [MAXC];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   exp_bits [512];
  bit   exp_rdy  [512];
  int   exp_len;
  bit   exp_tail;
  logic [7:0] fb [8];
  int   first_pos;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && cyc < MAXC) begin
    line_bit[cyc] = tx_bit;
    line_rdy[cyc] = in_ready;
  end

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic put(bit b, bit r, inout int p, inout int ones, inout bit st);
    exp_bits[p] = b; exp_rdy[p] = r; p++; st = 0;
    if (b) ones++; else ones = 0;
    if (ones == 5) begin
      exp_bits[p] = 0; exp_rdy[p] = 0; p++; ones = 0; st = 1;
    end
  endtask

  // Independent model: long division for the check field, own zero insertion.
  task automatic build(int len, bit underrun);
    bit m [128];
    int p = 0;
    int ones = 0;
    bit st = 0;
    for (int i = 0; i < 8; i++) begin
      exp_bits[p] = (i != 0 && i != 7); exp_rdy[p] = (i == 7); p++;
    end
    for (int i = 0; i < len; i++)
      for (int j = 7; j >= 0; j--)
        put(fb[i][j], (j == 0) && ((i < len - 1) || underrun), p, ones, st);
    for (int k = 0; k < 128; k++) m[k] = 0;
    for (int i = 0; i < len; i++)
      for (int j = 7; j >= 0; j--) m[8*i + 7 - j] = fb[i][j];
    for (int k = 0; k < 8*len; k++)
      if (m[k]) for (int g = 0; g <= 16; g++) m[k+g] = m[k+g] ^ GEN[16-g];
    for (int g = 0; g < 16; g++) put(m[8*len + g], 0, p, ones, st);
    exp_tail = st;
    for (int i = 0; i < 8; i++) begin
      exp_bits[p] = (i != 0 && i != 7); exp_rdy[p] = (i == 7); p++;
    end
    exp_len = p;
  endtask

  task automatic send_frame(int len, bit underrun);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = fb[i];
      in_last  = (i == len - 1) && !underrun;
      while (!in_ready) @(negedge clk);
      if (i == 0) first_pos = cyc - 7;
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic compare(string tag);
    int fb_i = -1;
    int fr_i = -1;
    while (cyc < first_pos + exp_len + 2) @(negedge clk);
    for (int i = 0; i < exp_len; i++) begin
      if (fb_i < 0 && line_bit[first_pos+i] != exp_bits[i]) fb_i = i;
      if (fr_i < 0 && line_rdy[first_pos+i] != exp_rdy[i]) fr_i = i;
    end
    if (fb_i < 0) check(1, "", 0, 0);
    else check(0, {"R2 R3 R4 R5 line bit ", tag}, int'(line_bit[first_pos+fb_i]), int'(exp_bits[fb_i]));
    if (fr_i < 0) check(1, "", 0, 0);
    else check(0, {"R6 R7 R8 ready pattern ", tag}, int'(line_rdy[first_pos+fr_i]), int'(exp_rdy[fr_i]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int pa, la, maxrun, run;
    bit found;
    // R12: reset state
    repeat (4) @(negedge clk);
    check(in_ready == 1'b0, "R12 in_ready during reset", int'(in_ready), 0);
    check(tx_bit == 1'b0, "R12 tx_bit during reset", int'(tx_bit), 0);
    rst_n = 1'b1;
    // R1 idle fill, R12 phase after release
    repeat (44) @(negedge clk);
    begin
      int bad = 0;
      for (int i = 0; i < 40; i++)
        if (line_bit[i] != ((i % 8) != 0 && (i % 8) != 7) || line_rdy[i] != ((i % 8) == 7)) bad++;
      check(bad == 0, "R1 R12 idle flag fill", bad, 0);
    end
    // Vector table walk
    foreach (VEC[v]) begin
      int len = int'(VEC[v][39:32]);
      fb[0] = VEC[v][31:24]; fb[1] = VEC[v][23:16];
      fb[2] = VEC[v][15:8];  fb[3] = VEC[v][7:0];
      build(len, 0);
      send_frame(len, 0);
      compare($sformatf("vector %0d", v));
      repeat (10) @(negedge clk);
    end
    // R9: underrun closes the frame
    fb[0] = 8'hC3; fb[1] = 8'h81; fb[2] = 8'hFF;
    build(3, 1);
    send_frame(3, 1);
    compare("R9 underrun");
    repeat (10) @(negedge clk);
    // R10: shared flag between frames
    fb[0] = 8'hF8; fb[1] = 8'h1F;
    build(2, 0);
    la = exp_len;
    send_frame(2, 0);
    pa = first_pos;
    fb[0] = 8'h55; fb[1] = 8'hFC; fb[2] = 8'h3E;
    build(3, 0);
    send_frame(3, 0);
    check(first_pos == pa + la - 8, "R10 next frame opens on closing flag", first_pos, pa + la - 8);
    compare("R10 second frame");
    repeat (10) @(negedge clk);
    // R11: search for a check field ending in an insertion
    found = 0;
    for (int k = 0; k < 4096 && !found; k++) begin
      fb[0] = k[15:8]; fb[1] = k[7:0];
      build(2, 0);
      if (exp_tail) found = 1;
    end
    check(found, "R11 trailing insertion frame found", int'(found), 1);
    if (found) begin
      send_frame(2, 0);
      compare("R11 trailing insertion");
    end
    repeat (20) @(negedge clk);
    // R3: longest run of ones on the line
    maxrun = 0; run = 0;
    for (int i = 0; i < cyc && i < MAXC; i++) begin
      run = line_bit[i] ? run + 1 : 0;
      if (run > maxrun) maxrun = run;
    end
    check(maxrun <= 6, "R3 longest run of ones on line", maxrun, 6);
    summary();
    $finish;
  end
endmodule